// File: doc/BRIEF.md
# Handshake Output Port Controller

This block sits between a locally clocked island and a four-phase bundled-data link. It turns a two-phase transfer request from the island into a full four-phase exchange with the link partner. It also asks the island's pausable clock generator to stop while the data is being handed over. The controller runs on a fast sampling clock that is independent of every party it talks to. Each incoming control line first passes through a synchronizer chain, and every output comes straight from a flop.

The island asks for a transfer by flipping its enable line in either direction. The controller answers by flipping its transfer-acknowledge line once that transfer is fully done. The island therefore knows nothing is outstanding when the two levels match. An elaboration parameter picks one of two stall policies. In demand mode the island clock is held from the very start of the transfer. In poll mode the request goes out first, the island keeps running, and the clock is held only briefly once the partner has answered.

If the enable line flips again while a transfer is still running, that flip is remembered. It is served as soon as the controller is back at rest. Only one such flip can be held. The island keeps at most one transfer waiting behind the one in flight.

Top module: `hs_out_port`

## Requirements
- R1: While reset is asserted (synchronous, active low), the pause request, link request and transfer-acknowledge outputs are all low, and the controller is idle.
- R2: Each change of the enable level, rising or falling, produces exactly one complete transfer. An enable that holds its level produces no activity on any output.
- R3: Demand mode (MODE = 0): a transfer begins by raising the pause request with the link request low. The link request rises only after the pause acknowledge has been seen high.
- R4: Poll mode (MODE = 1): a transfer begins by raising the link request while the pause request stays low. The pause request rises only after the link acknowledge has been seen high.
- R5: Both modes release in this order. First the link request drops while the pause request stays high. Once the link acknowledge is seen low, the pause request drops. No two of the three outputs change in the same sampling cycle.
- R6: The transfer-acknowledge output toggles exactly once per transfer, only after the pause acknowledge is seen low. When nothing is pending it equals the enable level.
- R7: An enable change that arrives while a transfer is in flight is held. It starts one further transfer after the controller returns to idle.
- R8: With the default two synchronizer stages, each output step that waits on the pause acknowledge or the link acknowledge appears exactly 3 sampling cycles after that input changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_en_i | input | 1 | Two-phase transfer request from the island; any level change asks for one transfer |
| xfer_ack_o | output | 1 | Two-phase completion toggle back to the island |
| pause_req_o | output | 1 | Request to the clock generator to hold the island clock |
| pause_ack_i | input | 1 | Clock generator reports the island clock is held |
| link_req_o | output | 1 | Four-phase request to the link partner |
| link_ack_i | input | 1 | Four-phase acknowledge from the link partner |

## Verification
The bench drives both a demand-mode and a poll-mode instance. Each faces a clock-generator model and a link-partner model that answer after random delays. Every output step is checked against the expected order for its mode, and the latency from the input that enabled it is measured. A controller that raised the link request before the pause acknowledge, or paused early in poll mode, shows up as an out-of-order step. So does one that released the pause before the link acknowledge fell, or changed two outputs at once. The bench also flips the enable again while a transfer is in flight and fires transfers back to back. A design that dropped the held flip, or toggled the acknowledge twice or not at all, is caught by the final count and level comparisons. Quiet windows with a steady enable catch a controller that starts transfers on its own.

// File: rtl/hs_port_pkg.sv
// Shared types for the handshake output port controller.
// Assumes nothing beyond a single sampling clock domain.
package hs_port_pkg;

    // Stall policy, fixed at elaboration.
    typedef enum logic {
        MODE_DEMAND = 1'b0,
        MODE_POLL   = 1'b1
    } port_mode_e;

    // Controller sequencing states.
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_HOLD_CLK  = 3'd1,
        ST_REQ       = 3'd2,
        ST_HOLD_LATE = 3'd3,
        ST_DROP_REQ  = 3'd4,
        ST_DROP_HOLD = 3'd5
    } port_state_e;

endpackage

// File: rtl/hs_sync.sv
// Multi-stage level synchronizer.
// Each bit of d_i passes through STAGES flops on clk. Assumes the inputs
// are level signals that stay stable long enough to be captured. Reset
// clears every stage to zero.
module hs_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First capture flop, fed from the asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= d_i;
            end
        end else begin : g_chain
            // Further resolution flops.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_o = stage_q[LAST];

endmodule

// File: rtl/hs_toggle_track.sv
// Two-phase bookkeeping toward the island.
// Keeps the enable level that was last accepted. A transfer is pending
// while the synchronized enable differs from it. Toggles the completion
// line once per finished transfer. Assumes the island keeps at most one
// change outstanding beyond the one in flight.
module hs_toggle_track (
    input  logic clk,
    input  logic rst_n,
    input  logic en_s_i,
    input  logic take_i,
    input  logic done_i,
    output logic pending_o,
    output logic ta_o
);

    logic taken_lvl_q;
    logic ta_q;

    // Remember the enable level at the moment a transfer is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)      taken_lvl_q <= 1'b0;
        else if (take_i) taken_lvl_q <= en_s_i;
    end

    // Flip the completion toggle when a transfer finishes.
    always_ff @(posedge clk) begin
        if (!rst_n)      ta_q <= 1'b0;
        else if (done_i) ta_q <= ~ta_q;
    end

    assign pending_o = en_s_i ^ taken_lvl_q;
    assign ta_o      = ta_q;

    // A transfer is only started when an enable change is waiting (R7).
    assert_take_pending_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> pending_o);

    // Completion and acceptance never coincide: completion happens away from idle (R6).
    assert_done_not_take_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        done_i |-> !take_i);

endmodule

// File: rtl/hs_port_fsm.sv
// Handshake sequencer for the output port.
// Drives the pause request and the link request from flops, in the order
// set by MODE. Reacts only to synchronized acknowledges. Assumes the clock
// generator and the link partner follow four-phase rules: each acknowledge
// follows its request up and down.
module hs_port_fsm
    import hs_port_pkg::*;
#(
    parameter port_mode_e MODE = MODE_DEMAND
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pending_i,
    input  logic pack_s_i,
    input  logic ack_s_i,
    output logic take_o,
    output logic done_o,
    output logic pr_o,
    output logic req_o
);

    localparam bit IS_DEMAND = (MODE == MODE_DEMAND);

    port_state_e st_q, st_n;
    logic        pr_q, req_q;

    // Pause request level held in each state.
    function automatic logic pause_of(port_state_e s);
        case (s)
            ST_HOLD_CLK, ST_HOLD_LATE, ST_DROP_REQ: pause_of = 1'b1;
            ST_REQ:                                 pause_of = IS_DEMAND;
            default:                                pause_of = 1'b0;
        endcase
    endfunction

    // Link request level held in each state.
    function automatic logic req_of(port_state_e s);
        req_of = (s == ST_REQ) || (s == ST_HOLD_LATE);
    endfunction

    // Next-state choice for the handshake sequence.
    always_comb begin
        st_n = st_q;
        case (st_q)
            ST_IDLE:      if (pending_i) st_n = IS_DEMAND ? ST_HOLD_CLK : ST_REQ;
            ST_HOLD_CLK:  if (pack_s_i)  st_n = ST_REQ;
            ST_REQ:       if (ack_s_i)   st_n = IS_DEMAND ? ST_DROP_REQ : ST_HOLD_LATE;
            ST_HOLD_LATE: if (pack_s_i)  st_n = ST_DROP_REQ;
            ST_DROP_REQ:  if (!ack_s_i)  st_n = ST_DROP_HOLD;
            ST_DROP_HOLD: if (!pack_s_i) st_n = ST_IDLE;
            default:                     st_n = ST_IDLE;
        endcase
    end

    // State and glitch-free registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            pr_q  <= 1'b0;
            req_q <= 1'b0;
        end else begin
            st_q  <= st_n;
            pr_q  <= pause_of(st_n);
            req_q <= req_of(st_n);
        end
    end

    assign take_o = (st_q == ST_IDLE) && pending_i;
    assign done_o = (st_q == ST_DROP_HOLD) && !pack_s_i;
    assign pr_o   = pr_q;
    assign req_o  = req_q;

    if (IS_DEMAND) begin : g_demand_chk
        // Demand mode: the link request only rises with the clock already held (R3).
        assert_req_after_pause_R3 : assert property (@(posedge clk) disable iff (!rst_n)
            $rose(req_o) |-> pr_o);
    end else begin : g_poll_chk
        // Poll mode: the pause request only rises with the link request up (R4).
        assert_pause_after_req_R4 : assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pr_o) |-> req_o);
        // Poll mode: a new request goes out with the island still running (R4).
        assert_poll_runs_R4 : assert property (@(posedge clk) disable iff (!rst_n)
            $rose(req_o) |-> !pr_o);
    end

    // The link request drops while the clock is still held (R5).
    assert_drop_req_held_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_o) |-> pr_o);

    // The pause is released only after the link request is down (R5).
    assert_release_last_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pr_o) |-> !req_o);

    // Completion is reported only with both requests low (R6).
    assert_done_quiet_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!pr_o && !req_o));

endmodule

// File: rtl/hs_out_port.sv
// Handshake output port controller, top level.
// Bridges a two-phase island request to a four-phase link, and stalls the
// island clock generator according to MODE. All three incoming control
// lines are treated as asynchronous and synchronized on clk. Assumes clk
// is fast compared with the island clock and the partner response times.
module hs_out_port
    import hs_port_pkg::*;
#(
    parameter port_mode_e MODE        = MODE_DEMAND,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_en_i,
    output logic xfer_ack_o,
    output logic pause_req_o,
    input  logic pause_ack_i,
    output logic link_req_o,
    input  logic link_ack_i
);

    localparam int N_ASYNC = 3;

    logic [N_ASYNC-1:0] async_in, sync_out;
    logic en_s, pack_s, ack_s;
    logic pending, take, done;

    assign async_in = {xfer_en_i, pause_ack_i, link_ack_i};
    assign {en_s, pack_s, ack_s} = sync_out;

    hs_sync #(
        .WIDTH  (N_ASYNC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (async_in),
        .q_o   (sync_out)
    );

    hs_toggle_track u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_s_i    (en_s),
        .take_i    (take),
        .done_i    (done),
        .pending_o (pending),
        .ta_o      (xfer_ack_o)
    );

    hs_port_fsm #(
        .MODE (MODE)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending_i (pending),
        .pack_s_i  (pack_s),
        .ack_s_i   (ack_s),
        .take_o    (take),
        .done_o    (done),
        .pr_o      (pause_req_o),
        .req_o     (link_req_o)
    );

    // At most one output changes per cycle (R5).
    assert_single_step_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        $countones({pause_req_o ^ $past(pause_req_o),
                    link_req_o  ^ $past(link_req_o),
                    xfer_ack_o  ^ $past(xfer_ack_o)}) <= 1);

endmodule

// File: tb/hs_out_port_bench.sv
// Environment for one controller instance: a clock-generator model, a link
// partner model with random delays, an order/latency monitor and stimulus.
module hs_out_port_env
    import hs_port_pkg::*;
#(
    parameter port_mode_e MODE = MODE_DEMAND,
    parameter int         SEED = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  int   cyc,
    output int   chk,
    output int   bad,
    output logic fin
);

    localparam int LAT = 3;
    localparam int EV_PR_UP = 0, EV_REQ_UP = 1, EV_REQ_DN = 2, EV_PR_DN = 3, EV_TA = 4;

    logic en, pack, ack;
    logic ta, pr, req;
    logic p_pr, p_req, p_ta;
    int   m_chk = 0, m_bad = 0, i_chk = 0, i_bad = 0;
    int   issued = 0, completed = 0, events = 0;
    int   step = 0, pack_t = 0, ack_t = 0, pdly = 0, adly = 0;
    logic fin_q = 1'b0;

    assign chk = m_chk + i_chk;
    assign bad = m_bad + i_bad;
    assign fin = fin_q;

    hs_out_port #(.MODE(MODE)) u_hs_out_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .xfer_en_i   (en),
        .xfer_ack_o  (ta),
        .pause_req_o (pr),
        .pause_ack_i (pack),
        .link_req_o  (req),
        .link_ack_i  (ack)
    );

    // Expected output step at each position of a transfer.
    function automatic int exp_ev(int s);
        case (s)
            0: exp_ev = (MODE == MODE_DEMAND) ? EV_PR_UP : EV_REQ_UP;
            1: exp_ev = (MODE == MODE_DEMAND) ? EV_REQ_UP : EV_PR_UP;
            2: exp_ev = EV_REQ_DN;
            3: exp_ev = EV_PR_DN;
            default: exp_ev = EV_TA;
        endcase
    endfunction

    // Input that enables each step: 0 none, 1 pause acknowledge, 2 link acknowledge.
    function automatic int trig_of(int s);
        case (s)
            1: trig_of = (MODE == MODE_DEMAND) ? 1 : 2;
            2: trig_of = (MODE == MODE_DEMAND) ? 2 : 1;
            3: trig_of = 2;
            4: trig_of = 1;
            default: trig_of = 0;
        endcase
    endfunction

    function automatic string tag_of(int s);
        if (s < 2)       tag_of = (MODE == MODE_DEMAND) ? "R3" : "R4";
        else if (s < 4)  tag_of = "R5";
        else             tag_of = "R6";
    endfunction

    // Monitor outputs, then let the models answer after random delays.
    always @(negedge clk) begin
        if (!rst_n) begin
            pack = 1'b0; ack = 1'b0;
            p_pr = 1'b0; p_req = 1'b0; p_ta = 1'b0;
            step = 0;
        end else begin
            int nchg, ev, lat;
            nchg = int'(pr != p_pr) + int'(req != p_req) + int'(ta != p_ta);
            if (nchg > 1) begin
                m_chk++; m_bad++;
                $display("FAIL R5 %s: %0d outputs changed together, expected 1", MODE.name(), nchg);
            end else if (nchg == 1) begin
                events++;
                if (ta != p_ta)       ev = EV_TA;
                else if (pr != p_pr)  ev = pr ? EV_PR_UP : EV_PR_DN;
                else                  ev = req ? EV_REQ_UP : EV_REQ_DN;
                m_chk++;
                if (ev != exp_ev(step)) begin
                    m_bad++;
                    $display("FAIL %s %s: step %0d event %0d, expected %0d", tag_of(step), MODE.name(), step, ev, exp_ev(step));
                end
                if (trig_of(step) != 0) begin
                    lat = cyc - ((trig_of(step) == 1) ? pack_t : ack_t);
                    m_chk++;
                    if (lat != LAT) begin
                        m_bad++;
                        $display("FAIL R8 %s: step %0d latency %0d, expected %0d", MODE.name(), step, lat, LAT);
                    end
                end
                if (ev == EV_TA) begin
                    completed++;
                    m_chk++;
                    if (completed > issued) begin
                        m_bad++;
                        $display("FAIL R6 %s: completions %0d, expected at most %0d", MODE.name(), completed, issued);
                    end
                end
                step = (step + 1) % 5;
            end
            p_pr = pr; p_req = req; p_ta = ta;
            if (pack != pr) begin
                if (pdly == 0) begin pack = pr; pack_t = cyc; pdly = int'($urandom % 5); end
                else pdly--;
            end
            if (ack != req) begin
                if (adly == 0) begin ack = req; ack_t = cyc; adly = int'($urandom % 6); end
                else adly--;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        i_chk++;
        if (!ok) begin
            i_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, MODE.name(), act, exp);
        end
    endtask

    task automatic flip();
        en = ~en;
        issued++;
    endtask

    task automatic drain();
        while (completed != issued) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Stimulus: directed corner cases, then a random phase.
    initial begin
        int e0, u;
        en = 1'b0;
        u = int'($urandom(SEED));
        repeat (3) @(negedge clk);
        check({pr, req, ta} == 3'b000, "R1", int'({pr, req, ta}), 0);
        @(posedge rst_n);
        @(negedge clk);
        e0 = events;
        repeat (40) @(negedge clk);
        check(events == e0, "R2", events - e0, 0);

        flip(); drain();
        check(ta == en && completed == 1, "R2", completed, 1);
        flip(); drain();
        check(ta == en && completed == 2, "R2", completed, 2);

        flip(); repeat (4) @(negedge clk); flip(); drain();
        check(completed == issued, "R7", completed, issued);
        check(ta == en, "R6", int'(ta), int'(en));

        for (int k = 0; k < 5; k++) begin
            flip();
            while (completed != issued) @(negedge clk);
        end
        drain();
        check(completed == issued, "R2", completed, issued);

        for (int k = 0; k < 80; k++) begin
            repeat (int'($urandom % 15)) @(negedge clk);
            if (issued - completed <= 1) flip();
        end
        drain();
        check(completed == issued, "R7", completed, issued);
        check(ta == en, "R6", int'(ta), int'(en));

        e0 = events;
        repeat (30) @(negedge clk);
        check(events == e0, "R2", events - e0, 0);
        check(step == 0, "R5", step, 0);
        fin_q = 1'b1;
    end

endmodule

// Bench top: clock, reset, both mode instances, watchdog and summary.
module hs_out_port_bench;
    import hs_port_pkg::*;

    localparam int WD_LIMIT = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   cyc = 0;
    int   chk_d, bad_d, chk_p, bad_p;
    logic fin_d, fin_p;

    always #5 clk = ~clk;

    // Cycle count used for latency measurement.
    always @(posedge clk) cyc <= cyc + 1;

    hs_out_port_env #(.MODE(MODE_DEMAND), .SEED(11)) u_env_demand (
        .clk(clk), .rst_n(rst_n), .cyc(cyc), .chk(chk_d), .bad(bad_d), .fin(fin_d));

    hs_out_port_env #(.MODE(MODE_POLL), .SEED(29)) u_env_poll (
        .clk(clk), .rst_n(rst_n), .cyc(cyc), .chk(chk_p), .bad(bad_p), .fin(fin_p));

    initial begin
        int wd_bad;
        wd_bad = 0;
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        for (int n = 0; n < WD_LIMIT; n++) begin
            @(negedge clk);
            if (fin_d && fin_p) break;
        end
        if (!(fin_d && fin_p)) begin
            wd_bad = 1;
            $display("FAIL watchdog: run not finished, actual %0d expected 1", int'(fin_d && fin_p));
        end
        $display("[TB] %0d tests run, %0d failed", chk_d + chk_p + wd_bad, bad_d + bad_p + wd_bad);
        $finish;
    end

endmodule